// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-attached watchdog. A fixed divider brings the system clock down to a slow tick, and a counter runs on that tick whenever the timer is switched on. Software chooses the timeout by writing a power-of-two exponent. It keeps the system alive by writing a 16-bit restart key into the upper half of the control word before the count runs out. A wrong value does nothing. If the count does reach its terminal value, the block raises a one-cycle reset request and records the event in a sticky cause flag.

Software switches the timer on and off through set and clear aliases of the control word, so no read-modify-write sequence is needed. The cause flags live in a separate status word. They are reset only by power-on reset or by a clear-alias write, so firmware can still read them after the system reset that the watchdog itself triggered. A clock-select field and a window flag are stored and read back, but they have no effect on counting. The bus access in the cycle right after the timer is switched off is discarded.

Top module: `guard_timer`

## Requirements
- R1: After power-on reset the control word (offset 0x00) and the status word (offset 0x10) both read zero, and `wdt_reset_req` is low.
- R2: While control bit 15 is zero the count stays at zero and `wdt_reset_req` never rises. A later enable therefore always starts from a full timeout.
- R3: When control bit 15 is set and the exponent in bits 12:8 is P, `wdt_reset_req` rises exactly 32·2^P clock cycles after the enabling write. It stays high for one cycle.
- R4: A write to offset 0x00 with byte enables 3:2 both set and data bits 31:16 equal to 0x5743 restarts the count from zero. The next request then comes 32·2^P cycles after that write.
- R5: An upper-half write carrying any other value, or a key that reaches only one byte lane, leaves the count running undisturbed.
- R6: A write to the set alias (offset 0x08) sets only the control bits written as one. A write to the clear alias (offset 0x04) clears only the control bits written as one.
- R7: Control bit 15 is the enable, bits 12:8 the exponent, bits 7:6 the clock select and bit 0 the window flag. All other bits read zero. Direct writes at offset 0x00 update only the byte lanes whose enables are set.
- R8: On a timeout, status bit 4 is set. Bit 2 is also set if `cpu_idle` is high at that moment, and bit 3 if `cpu_sleep` is high. Writing one to a status bit through the clear alias (offset 0x14, byte lane 0) clears it.
- R9: `sys_rst` clears the control word and stops the timer but leaves the status flags intact. Only `por_rst` clears the status flags.
- R10: Any bus access in the cycle right after a write that turns bit 15 from one to zero has no effect. The following access is handled normally.
- R11: Once a timeout fires, the count restarts on its own, and the next request follows 32·2^P cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Synchronous power-on reset; clears everything |
| sys_rst | input | 1 | Synchronous system reset; keeps status flags |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | High for write, low for read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| cpu_idle | input | 1 | Core is in idle mode |
| cpu_sleep | input | 1 | Core is in sleep mode |
| wdt_reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The assertions assume that the divider ratio is at least two. They also assume that resets are synchronous and last at least one full cycle, so a request can never be followed by a second one on the next cycle. The bench only drives bus fields and mode inputs at falling edges and keeps each access to a single cycle. It uses only the decoded offsets, and it measures the delay to each request in whole cycles from the falling edge after the relevant write. Exponents 0 to 3 are swept completely, and large exponents are used only where no timeout is expected.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam logic [15:0] CLEAR_KEY = 16'h5743;
  localparam int unsigned ON_BIT   = 15;
  localparam int unsigned PS_LSB   = 8;
  localparam int unsigned PS_W     = 5;
  localparam logic [15:0] CTRL_MASK = 16'h9FC1;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_CTRL_CLR, SEL_CTRL_SET, SEL_STAT, SEL_STAT_CLR, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(logic [7:0] ofs);
    case (ofs)
      8'h00:   return SEL_CTRL;
      8'h04:   return SEL_CTRL_CLR;
      8'h08:   return SEL_CTRL_SET;
      8'h10:   return SEL_STAT;
      8'h14:   return SEL_STAT_CLR;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic             clr;

  assign clr  = rst | ~en | restart;
  assign tick = en & ~rst & (pre_q == LAST);

  generate
    if ((DIV & (DIV - 1)) == 0) begin : g_pow2
      always_ff @(posedge clk) begin
        if (clr) pre_q <= '0;
        else     pre_q <= pre_q + PRE_W'(1);
      end
    end else begin : g_any
      always_ff @(posedge clk) begin
        if (clr)       pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + PRE_W'(1);
      end
    end
  endgenerate

  // R3: ticks are separated by DIV-1 idle cycles, never back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/gt_postcount.sv
module gt_postcount #(
  parameter int unsigned PS_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            tick,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            fire,
  output logic            req
);
  localparam int unsigned CNT_W = 1 << PS_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_m1;

  assign term_m1 = (ONE << ps) - ONE;
  assign fire    = tick & ~restart & ~rst & (cnt_q == term_m1);

  always_ff @(posedge clk) begin
    if (rst || !en || restart) cnt_q <= '0;
    else if (fire)             cnt_q <= '0;
    else if (tick)             cnt_q <= cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= fire;
  end

  // R2: a disabled timer leaves the count at zero
  p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0));
  // R4: a key write restarts the count
  p_key_clears_r4: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0) && !req);
endmodule

// File: rtl/gt_regs.sv
module gt_regs
  import guard_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sys_rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              fire,
  input  logic              cpu_idle,
  input  logic              cpu_sleep,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ctrl_on,
  output logic [PS_W-1:0]   ctrl_ps,
  output logic              restart
);
  logic [15:0] ctrl_q, ctrl_n, bmask, wlo;
  logic [2:0]  st_q, st_n, st_clr, st_set;
  logic        lock_q, acc, wr, rd, clr_wdt;
  reg_sel_e    sel;

  assign sel   = decode_ofs(8'(bus_addr));
  assign acc   = bus_en & ~lock_q;
  assign wr    = acc & bus_wr;
  assign rd    = acc & ~bus_wr;
  assign bmask = {{8{bus_be[1]}}, {8{bus_be[0]}}} & CTRL_MASK;
  assign wlo   = bus_wdata[15:0] & bmask;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr) begin
      case (sel)
        SEL_CTRL:     ctrl_n = (ctrl_q & ~bmask) | wlo;
        SEL_CTRL_SET: ctrl_n = ctrl_q | wlo;
        SEL_CTRL_CLR: ctrl_n = ctrl_q & ~wlo;
        default:      ctrl_n = ctrl_q;
      endcase
    end
  end

  assign restart = wr & (sel == SEL_CTRL) & (bus_be[3:2] == 2'b11)
                 & (bus_wdata[31:16] == CLEAR_KEY);

  assign st_clr  = (wr && sel == SEL_STAT_CLR && bus_be[0]) ? bus_wdata[4:2] : 3'b000;
  assign clr_wdt = st_clr[2];
  assign st_set  = fire ? {1'b1, cpu_sleep, cpu_idle} : 3'b000;
  assign st_n    = (st_q & ~st_clr) | st_set;

  always_ff @(posedge clk) begin
    if (por_rst) st_q <= '0;
    else         st_q <= st_n;
  end

  always_ff @(posedge clk) begin
    if (por_rst || sys_rst) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      lock_q <= ctrl_q[ON_BIT] & ~ctrl_n[ON_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst || sys_rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (sel)
        SEL_CTRL, SEL_CTRL_CLR, SEL_CTRL_SET: bus_rdata <= {16'h0, ctrl_q};
        SEL_STAT, SEL_STAT_CLR:               bus_rdata <= {27'h0, st_q, 2'b00};
        default:                              bus_rdata <= '0;
      endcase
    end
  end

  assign ctrl_on = ctrl_q[ON_BIT];
  assign ctrl_ps = ctrl_q[PS_LSB +: PS_W];

  // R8: a timeout always leaves the cause flag set
  p_fire_flag_r8: assert property (@(posedge clk) disable iff (por_rst)
    fire |=> st_q[2]);
  // R9: the cause flag only falls through a clear write or power-on reset
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (por_rst)
    (st_q[2] && !clr_wdt) |=> st_q[2]);
  // R10: the cycle after a disable cannot change the control word
  p_lockout_r10: assert property (@(posedge clk) disable iff (por_rst || sys_rst)
    lock_q |=> (ctrl_q == $past(ctrl_q)));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PRE_DIV = 32
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sys_rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cpu_idle,
  input  logic              cpu_sleep,
  output logic              wdt_reset_req
);
  logic            rst_any, on, restart, tick, fire;
  logic [PS_W-1:0] ps;

  assign rst_any = por_rst | sys_rst;

  gt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .fire(fire),
    .cpu_idle(cpu_idle), .cpu_sleep(cpu_sleep), .bus_rdata(bus_rdata),
    .ctrl_on(on), .ctrl_ps(ps), .restart(restart)
  );

  gt_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst_any), .en(on), .restart(restart), .tick(tick)
  );

  gt_postcount #(.PS_W(PS_W)) u_post (
    .clk(clk), .rst(rst_any), .en(on), .tick(tick), .restart(restart),
    .ps(ps), .fire(fire), .req(wdt_reset_req)
  );

  // R2: nothing is requested while the timer is off
  p_off_no_req_r2: assert property (@(posedge clk) disable iff (rst_any)
    !on |=> !wdt_reset_req);
  // R3: the request lasts a single cycle
  p_pulse_one_r3: assert property (@(posedge clk) disable iff (rst_any)
    wdt_reset_req |=> !wdt_reset_req);
endmodule

// File: tb/sim_guard_timer.sv
module sim_guard_timer;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, sys_rst = 1'b0;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        cpu_idle = 1'b0, cpu_sleep = 1'b0;
  logic        wdt_reset_req;

  always #4 clk = ~clk;

  guard_timer u0 (
    .clk(clk), .por_rst(por_rst), .sys_rst(sys_rst), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_idle(cpu_idle),
    .cpu_sleep(cpu_sleep), .wdt_reset_req(wdt_reset_req)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_por();
    por_rst = 1'b1;
    @(negedge clk); @(negedge clk);
    por_rst = 1'b0;
  endtask

  task automatic bus_write(logic [4:0] a, logic [3:0] be, logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 4'hF;
    @(negedge clk);
    bus_en = 1'b0; bus_be = '0;
    d = bus_rdata;
  endtask

  task automatic wait_pulse(int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wdt_reset_req && n < limit);
    if (!wdt_reset_req) n = -1;
  endtask

  task automatic count_pulses(int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wdt_reset_req) seen++;
    end
  endtask

  initial begin
    logic [31:0] rd;
    int n;

    do_por();
    // R1: reset state
    check("R1 req low", {31'h0, wdt_reset_req}, 32'h0);
    bus_read(5'h00, rd); check("R1 ctrl", rd, 32'h0);
    bus_read(5'h10, rd); check("R1 status", rd, 32'h0);

    // R3 / R11 / R8: sweep the exponent over 0..3
    for (int p = 0; p < 4; p++) begin
      do_por();
      bus_write(5'h00, 4'h3, 32'h8000 | (p << 8));
      wait_pulse(4000, n);
      check($sformatf("R3 delay p=%0d", p), n, 32 << p);
      @(negedge clk);
      check($sformatf("R3 width p=%0d", p), {31'h0, wdt_reset_req}, 32'h0);
      wait_pulse(4000, n);
      check($sformatf("R11 rearm p=%0d", p), n, (32 << p) - 1);
      bus_read(5'h10, rd);
      check($sformatf("R8 flag p=%0d", p), rd, 32'h10);
    end

    // R2: disabled timer stays quiet and holds zero
    do_por();
    bus_write(5'h00, 4'h3, 32'h0000_0000);
    count_pulses(300, n);
    check("R2 no request while off", n, 0);
    bus_write(5'h08, 4'h3, 32'h0000_8000);
    wait_pulse(4000, n);
    check("R2 full timeout after enable", n, 32);

    // R4: correct key restarts count
    do_por();
    bus_write(5'h00, 4'h3, 32'h0000_8200);
    count_pulses(100, n);
    check("R4 no early request", n, 0);
    bus_write(5'h00, 4'b1100, 32'h5743_0000);
    wait_pulse(4000, n);
    check("R4 restart delay", n, 128);

    // R5: wrong key, and key on one lane only
    do_por();
    bus_write(5'h00, 4'h3, 32'h0000_8200);
    count_pulses(100, n);
    bus_write(5'h00, 4'b1100, 32'h5744_0000);
    wait_pulse(4000, n);
    check("R5 wrong key ignored", n, 27);
    do_por();
    bus_write(5'h00, 4'h3, 32'h0000_8200);
    count_pulses(100, n);
    bus_write(5'h00, 4'b0100, 32'h5743_0000);
    wait_pulse(4000, n);
    check("R5 single-lane key ignored", n, 27);

    // R7 / R6: layout, set and clear aliases
    do_por();
    bus_write(5'h00, 4'h3, 32'h0000_0381);
    bus_read(5'h00, rd); check("R7 fields", rd, 32'h0381);
    bus_write(5'h08, 4'h3, 32'h0000_8000);
    bus_read(5'h00, rd); check("R6 set alias", rd, 32'h8381);
    bus_write(5'h04, 4'h3, 32'h0000_0001);
    bus_read(5'h00, rd); check("R6 clear alias", rd, 32'h8380);
    bus_write(5'h00, 4'hF, 32'hFFFF_FFFF);
    bus_read(5'h00, rd); check("R7 unused bits", rd, 32'h9FC1);
    bus_write(5'h00, 4'b0001, 32'h0000_0000);
    bus_read(5'h00, rd); check("R7 byte lanes", rd, 32'h9F00);

    // R10: access right after disable is dropped
    bus_write(5'h04, 4'h3, 32'h0000_8000);
    bus_write(5'h00, 4'h3, 32'h0000_0200);
    bus_read(5'h00, rd); check("R10 dropped write", rd, 32'h1F00);
    bus_write(5'h00, 4'h3, 32'h0000_0200);
    bus_read(5'h00, rd); check("R10 later write", rd, 32'h0200);

    // R8 / R9: cause flags, system reset, power-on reset
    do_por();
    cpu_sleep = 1'b1;
    bus_write(5'h00, 4'h3, 32'h0000_8000);
    wait_pulse(4000, n);
    cpu_sleep = 1'b0;
    bus_read(5'h10, rd); check("R8 sleep flag", rd, 32'h18);
    sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
    bus_read(5'h00, rd); check("R9 ctrl cleared", rd, 32'h0);
    bus_read(5'h10, rd); check("R9 flags kept", rd, 32'h18);
    count_pulses(100, n);
    check("R9 stopped", n, 0);
    bus_write(5'h14, 4'h1, 32'h0000_0010);
    bus_read(5'h10, rd); check("R8 clear alias", rd, 32'h08);
    cpu_idle = 1'b1;
    bus_write(5'h00, 4'h3, 32'h0000_8000);
    wait_pulse(4000, n);
    cpu_idle = 1'b0;
    bus_read(5'h10, rd); check("R8 idle flag", rd, 32'h1C);
    do_por();
    bus_read(5'h10, rd); check("R9 por clears", rd, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule